// File: doc/BRIEF.md
# Dual-Channel Segmented DAC Code Decoder

This block is the digital front end of a two-channel (I and Q) segmented current-steering converter with 11-bit words. Each word is cut into a 6-bit upper part, which drives 63 equally weighted unary cells, and a 5-bit lower part, which drives binary-weighted cells without change. The unary enables come from a grid of cells. A 3-bit row thermometer decoder and a 3-bit column thermometer decoder feed this grid, so no flat 6-to-63 decoder is needed.

An I/Q word pair enters through a valid/ready input. All control lines for both channels are captured in one register stage, so every switch changes on the same clock edge. The registered sample is presented through a valid/ready output. The input is ready whenever the output register is empty or is being emptied in the same cycle. While the consumer holds `out_ready` low with `out_valid` high, the outputs and `out_valid` stay frozen and no new word is taken. A word pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. It is delivered on a rising edge where `out_valid` and `out_ready` are both high.

Top module: `seg_dac_front`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` and every unary and binary output to zero on the next rising edge.
- R2: The binary outputs of each channel equal bits [4:0] of that channel's accepted input word.
- R3: The number of set unary enables of a channel equals the unsigned value of bits [10:5] of its word, so popcount × 32 + binary equals the input word.
- R4: The unary enables fill contiguously from bit 0: enable k is set exactly when k is less than the upper value. Enable index = row × 8 + column, where the row is bits [10:8] and the column is bits [7:5].
- R5: A word pair accepted on one edge is presented on the outputs, with `out_valid` high, from the very next edge. Words leave in the order they were accepted.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs and `out_valid` hold.
- R7: Upper value 0 gives no unary enables. Word 2047 gives all 63 enables and a binary value of 31.
- R8: The I and Q channels are decoded from their own words only and are updated on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word pair present |
| in_ready | output | 1 | Block can take a word pair |
| code_i | input | 11 | I-channel input word |
| code_q | input | 11 | Q-channel input word |
| out_valid | output | 1 | Registered sample present |
| out_ready | input | 1 | Consumer takes the sample |
| i_unary | output | 63 | I-channel unary cell enables |
| i_bin | output | 5 | I-channel binary cell enables |
| q_unary | output | 63 | Q-channel unary cell enables |
| q_bin | output | 5 | Q-channel binary cell enables |

## Verification
Taking a new word and handing the current sample to the consumer can happen on the same edge. The output register is then emptied and reloaded at once. The bench provokes this by keeping a word offered while `out_ready` follows a pattern that is mostly high with regular stalls. The scoreboard judges every delivered sample against the queued words in order. A separate check confirms that a stalled sample stays frozen until it is taken. All 2048 I words are swept, each paired with a different Q word, and each pair is checked for count, contiguous fill and binary pass-through.

// File: rtl/dacseg_pkg.sv
package dacseg_pkg;
  parameter int WORD_W = 11;
  parameter int LSB_W  = 5;
  parameter int MSB_W  = WORD_W - LSB_W;
  parameter int ROW_W  = MSB_W / 2;
  parameter int COL_W  = MSB_W - ROW_W;
  parameter int CELLS  = (1 << MSB_W) - 1;
  parameter int NCH    = 2;
endpackage

// File: rtl/thermo_dec.sv
// Binary to thermometer: output k is high when the input exceeds k.
module thermo_dec #(
  parameter int IN_W = 3,
  localparam int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  val,
  output logic [OUT_W-1:0] th
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    assign th[k] = (val > IN_W'(k));
  end
endmodule

// File: rtl/unary_grid.sv
// Combines row and column thermometer codes into row-major unary cells.
module unary_grid #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3,
  localparam int NROW  = 1 << ROW_W,
  localparam int NCOL  = 1 << COL_W,
  localparam int NCELL = NROW * NCOL - 1
) (
  input  logic [NROW-2:0]  row_th,
  input  logic [NCOL-2:0]  col_th,
  output logic [NCELL-1:0] cells
);
  logic [NROW-1:0] row_full;
  logic [NROW-1:0] row_part;
  logic [NCOL-1:0] col_on;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    if (r == NROW - 1) begin : g_last
      assign row_full[r] = 1'b0;
      assign row_part[r] = row_th[r-1];
    end else if (r == 0) begin : g_first
      assign row_full[r] = row_th[r];
      assign row_part[r] = ~row_th[r];
    end else begin : g_mid
      assign row_full[r] = row_th[r];
      assign row_part[r] = row_th[r-1] & ~row_th[r];
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    if (c == NCOL - 1) begin : g_last
      assign col_on[c] = 1'b0;
    end else begin : g_other
      assign col_on[c] = col_th[c];
    end
  end

  for (genvar r = 0; r < NROW; r++) begin : g_r
    for (genvar c = 0; c < NCOL; c++) begin : g_c
      if (r * NCOL + c < NCELL) begin : g_cell
        assign cells[r*NCOL+c] = row_full[r] | (row_part[r] & col_on[c]);
      end
    end
  end
endmodule

// File: rtl/seg_channel.sv
// One channel: split word, decode upper part, register all switch controls.
module seg_channel #(
  parameter int WORD_W = 11,
  parameter int LSB_W  = 5,
  localparam int MSB_W = WORD_W - LSB_W,
  localparam int ROW_W = MSB_W / 2,
  localparam int COL_W = MSB_W - ROW_W,
  localparam int CELLS = (1 << MSB_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] code,
  output logic [CELLS-1:0]  unary_q,
  output logic [LSB_W-1:0]  bin_q
);
  logic [MSB_W-1:0]        upper;
  logic [(1<<ROW_W)-2:0]   row_th;
  logic [(1<<COL_W)-2:0]   col_th;
  logic [CELLS-1:0]        cells_d;

  assign upper = code[WORD_W-1:LSB_W];

  thermo_dec #(.IN_W(ROW_W)) u_row (.val(upper[MSB_W-1:COL_W]), .th(row_th));
  thermo_dec #(.IN_W(COL_W)) u_col (.val(upper[COL_W-1:0]),     .th(col_th));

  unary_grid #(.ROW_W(ROW_W), .COL_W(COL_W)) u_grid (
    .row_th(row_th), .col_th(col_th), .cells(cells_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unary_q <= '0;
      bin_q   <= '0;
    end else if (load) begin
      unary_q <= cells_d;
      bin_q   <= code[LSB_W-1:0];
    end
  end
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front
  import dacseg_pkg::*;
#(
  parameter int WORD_W_P = dacseg_pkg::WORD_W,
  parameter int LSB_W_P  = dacseg_pkg::LSB_W,
  localparam int CELLS_P = (1 << (WORD_W_P - LSB_W_P)) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W_P-1:0] code_i,
  input  logic [WORD_W_P-1:0] code_q,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CELLS_P-1:0]  i_unary,
  output logic [LSB_W_P-1:0]  i_bin,
  output logic [CELLS_P-1:0]  q_unary,
  output logic [LSB_W_P-1:0]  q_bin
);
  logic                take;
  logic [WORD_W_P-1:0] codes [NCH];
  logic [CELLS_P-1:0]  un    [NCH];
  logic [LSB_W_P-1:0]  bn    [NCH];

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst)       out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  assign codes[0] = code_i;
  assign codes[1] = code_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    seg_channel #(.WORD_W(WORD_W_P), .LSB_W(LSB_W_P)) u_chan (
      .clk(clk), .rst(rst), .load(take), .code(codes[ch]),
      .unary_q(un[ch]), .bin_q(bn[ch])
    );
  end

  assign i_unary = un[0];
  assign i_bin   = bn[0];
  assign q_unary = un[1];
  assign q_bin   = bn[1];
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
  parameter int WORD_W_P = 11,
  parameter int LSB_W_P  = 5,
  localparam int CELLS_P = (1 << (WORD_W_P - LSB_W_P)) - 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [WORD_W_P-1:0] code_i,
  input logic [WORD_W_P-1:0] code_q,
  input logic                out_valid,
  input logic                out_ready,
  input logic [CELLS_P-1:0]  i_unary,
  input logic [LSB_W_P-1:0]  i_bin,
  input logic [CELLS_P-1:0]  q_unary,
  input logic [LSB_W_P-1:0]  q_bin
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && i_unary == '0 && q_unary == '0 && i_bin == '0 && q_bin == '0));

  assert_bin_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (i_bin == $past(code_i[LSB_W_P-1:0]) &&
                                q_bin == $past(code_q[LSB_W_P-1:0])));

  assert_count_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      ($countones(i_unary) == int'($past(code_i[WORD_W_P-1:LSB_W_P])) &&
       $countones(q_unary) == int'($past(code_q[WORD_W_P-1:LSB_W_P]))));

  assert_fill_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((i_unary + 1'b1) & i_unary) == '0 &&
                   ((q_unary + 1'b1) & q_unary) == '0));

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_block_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(i_unary) && $stable(q_unary) &&
                                   $stable(i_bin) && $stable(q_bin)));
endmodule

bind seg_dac_front seg_dac_front_chk #(.WORD_W_P(WORD_W_P), .LSB_W_P(LSB_W_P)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .code_i(code_i), .code_q(code_q), .out_valid(out_valid), .out_ready(out_ready),
  .i_unary(i_unary), .i_bin(i_bin), .q_unary(q_unary), .q_bin(q_bin)
);

// File: tb/sim_seg_dac_front.sv
module sim_seg_dac_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [10:0] code_i = '0, code_q = '0;
  logic in_ready, out_valid;
  logic [62:0] i_unary, q_unary;
  logic [4:0]  i_bin, q_bin;

  always #10 clk = ~clk;

  seg_dac_front u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .code_i(code_i), .code_q(code_q), .out_valid(out_valid), .out_ready(out_ready),
    .i_unary(i_unary), .i_bin(i_bin), .q_unary(q_unary), .q_bin(q_bin)
  );

  typedef struct packed { logic [10:0] ci; logic [10:0] cq; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0, running = 0;
  int rmode = 0, cyc = 0;
  bit acc_flag = 0, acc_pend = 0;
  item_t acc_item, pend_item;
  bit held = 0;
  logic [62:0] h_iu, h_qu;
  logic [4:0]  h_ib, h_qb;

  task automatic chk(bit ok, string req, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [62:0] exp_un(logic [10:0] w);
    logic [63:0] t;
    t = (64'd1 << w[10:5]) - 64'd1;
    return t[62:0];
  endfunction

  task automatic check_chan(string nm, logic [10:0] w, logic [62:0] u, logic [4:0] b);
    chk(u == exp_un(w), "R4", $sformatf("%s unary act=%h exp=%h word=%0d", nm, u, exp_un(w), w));
    chk($countones(u) * 32 + int'(b) == int'(w), "R3",
        $sformatf("%s count*32+bin act=%0d exp=%0d", nm, $countones(u) * 32 + int'(b), w));
    chk(b == w[4:0], "R2", $sformatf("%s bin act=%0d exp=%0d", nm, b, w[4:0]));
    if (w[10:5] == 6'd0)
      chk(u == '0, "R7", $sformatf("%s zero upper act=%h exp=0", nm, u));
    if (w == 11'd2047)
      chk(u == {63{1'b1}} && b == 5'd31, "R7",
          $sformatf("%s full act=%h/%0d exp=all/31", nm, u, b));
  endtask

  // consumer ready pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (rmode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 5 != 2);
      default: out_ready <= (cyc % 3 == 0);
    endcase
  end

  // driver: offers a pair and pushes the expectation when accepted
  task automatic send(logic [10:0] a, logic [10:0] b);
    @(negedge clk);
    in_valid = 1'b1; code_i = a; code_q = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back('{ci: a, cq: b});
    acc_item = '{ci: a, cq: b};
    acc_flag = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (running && !rst) begin
      chk(in_ready == (!out_valid || out_ready), "R6",
          $sformatf("in_ready act=%0b exp=%0b", in_ready, !out_valid || out_ready));
      if (held)
        chk(out_valid && i_unary == h_iu && q_unary == h_qu && i_bin == h_ib && q_bin == h_qb,
            "R6", $sformatf("stall hold act=%0b/%h/%0d exp=1/%h/%0d", out_valid, i_unary, i_bin, h_iu, h_ib));
      if (acc_pend)
        chk(out_valid && i_bin == pend_item.ci[4:0] && q_bin == pend_item.cq[4:0], "R5",
            $sformatf("next-edge output act=%0b/%0d/%0d exp=1/%0d/%0d",
                      out_valid, i_bin, q_bin, pend_item.ci[4:0], pend_item.cq[4:0]));
      held = out_valid && !out_ready;
      h_iu = i_unary; h_qu = q_unary; h_ib = i_bin; h_qb = q_bin;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) chk(1'b0, "R5", "output with empty scoreboard act=1 exp=0");
        else begin
          item_t e;
          e = sb.pop_front();
          check_chan("I", e.ci, i_unary, i_bin);
          check_chan("Q(R8)", e.cq, q_unary, q_bin);
        end
      end
      acc_pend = acc_flag;
      pend_item = acc_item;
      acc_flag = 1'b0;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && i_unary == '0 && q_unary == '0 && i_bin == '0 && q_bin == '0, "R1",
        $sformatf("reset state act=%0b/%h/%h exp=0", out_valid, i_unary, q_unary));
    rst = 1'b0;
    running = 1'b1;
    // full sweep, steady consumer
    rmode = 0;
    for (int w = 0; w < 2048; w++) send(11'(w), 11'(2047 - w));
    idle();
    // stalls with back-to-back offers: accept and drain on the same edge
    rmode = 1;
    for (int w = 0; w < 300; w++) send(11'((w * 37) % 2048), 11'((w * 101 + 5) % 2048));
    send(11'd2047, 11'd0);
    send(11'd0, 11'd2047);
    idle();
    // heavy back-pressure with gaps
    rmode = 2;
    for (int w = 0; w < 200; w++) begin
      send(11'((w * 613) % 2048), 11'((w * 29) % 2048));
      if (w % 4 == 0) idle();
    end
    idle();
    rmode = 0;
    repeat (10) @(negedge clk);
    #3;
    chk(sb.size() == 0, "R5", $sformatf("drained queue act=%0d exp=0", sb.size()));
    chk(!out_valid, "R6", $sformatf("out_valid after drain act=%0b exp=0", out_valid));
    // reset mid-stream clears outputs
    send(11'd1234, 11'd999);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    running = 1'b0;
    sb.delete();
    @(negedge clk);
    chk(!out_valid && i_unary == '0 && q_unary == '0 && i_bin == '0 && q_bin == '0, "R1",
        $sformatf("mid-run reset act=%0b/%h/%0d exp=0", out_valid, i_unary, i_bin));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule